// File: doc/BRIEF.md
# Up/Down PWM Timer with Compare Output and Conversion Trigger

This block is a general-purpose counter for power-converter control loops. A 16-bit count runs against a programmable period in one of three patterns: a rising sawtooth that wraps to zero, a falling sawtooth that reloads the period, or a triangle that turns around at the period and at zero. The count is compared with a compare value to produce a PWM pin. In triangle mode this gives a centre-aligned waveform.

A power-of-two prescaler sets how often the count moves. Together with the period, it sets the PWM frequency. Software writes the period and compare values into holding copies. These are moved into the working registers only when the count passes through zero, so a running PWM cycle is never cut short. Three events latch into sticky flags: count equals period, count equals compare, and count at zero. A mask routes the flags to one interrupt line. A one-clock pulse marks the start of an ADC sample on either the zero event or the period event.

Top module: `pwm_gp_timer`

## Requirements
- R1: After reset the control, count, flag and mask registers read 0, and `pwm_out`, `adc_trig` and `irq` are low.
- R2: Register map by address: 0 control, 1 count, 2 compare, 3 period, 4 flags, 5 mask. The count, compare, period and mask read back the last value written. The compare and period read back their holding copies. A count write overrides any counting in that cycle.
- R3: With mode field 0 (continuous up), each tick adds one to the count. A tick that finds the count equal to the working period loads zero instead.
- R4: With mode field 1 (up/down), the count rises to the working period and then falls, and it rises again after reaching zero. The sequence for period P is 0,1..P,P-1..1,0,1.
- R5: With mode field 2 (down), each tick subtracts one from the count. A tick that finds the count at zero loads the working period.
- R6: Control bit 0 enables counting. Control bits [5:3] select a tick every 2^n enabled clocks, for n from 0 to 7. The count holds whenever `clk_en` is low, the enable bit is clear, or the mode field is 3. Control bits [2:1] hold the mode.
- R7: `pwm_out` is high exactly while the timer is enabled and the count is below the working compare value.
- R8: Compare and period writes reach the working registers only on a tick that leaves the count at zero, or at any time while the timer is disabled.
- R9: Flag bit 0 (period match), bit 1 (compare match) and bit 2 (zero) are each set by a tick that finds the count at that value. A flag stays set until a 1 is written to its bit at address 4.
- R10: `irq` is high exactly while some flag bit and the same mask bit are both set.
- R11: `adc_trig` goes high for the clock after a tick that finds the count at zero (control bit 6 = 0) or at the working period (control bit 6 = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Gate on the prescaler input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational from the address |
| pwm_out | output | 1 | Compare-driven PWM pin |
| adc_trig | output | 1 | One-clock start-of-conversion pulse |
| irq | output | 1 | Masked OR of the event flags |

## Verification
A corrupted count or direction bit shows on the count read port and on `pwm_out` at the very next tick. The bench compares both against a bench-side model on every clock of each vector. A wrong working period or compare value only shows once the count reaches that value. For that reason, the holding-copy test runs the count past the old period before it looks for the new wrap point. Faults in the flag or trigger path appear one clock after the event tick, as a wrong bit at address 4, on `irq`, or as a trigger pulse landing on the wrong step.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_UPDN = 2'd1,
    MODE_DN   = 2'd2,
    MODE_HOLD = 2'd3
  } tmr_mode_e;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } tmr_dir_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CNT  = 1;
  localparam int unsigned ADDR_CMP  = 2;
  localparam int unsigned ADDR_PER  = 3;
  localparam int unsigned ADDR_FLG  = 4;
  localparam int unsigned ADDR_MSK  = 5;

  localparam int unsigned NEV     = 3;
  localparam int unsigned EV_PER  = 0;
  localparam int unsigned EV_CMP  = 1;
  localparam int unsigned EV_ZERO = 2;

endpackage

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic            clk_en_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] msk;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      msk[i] = (i < int'(ps_i));
    end
  end

  always_comb begin
    div_d = div_q;
    if (!enable_i) begin
      div_d = '0;
    end else if (clk_en_i) begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick_o = enable_i && clk_en_i && ((div_q & msk) == msk);

  // With the fastest setting every enabled clock must tick
  assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && clk_en_i && ps_i == '0) |-> tick_o);

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             tick_i,
  input  tmr_mode_e        mode_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [CNT_W-1:0] per_hold_i,
  input  logic [CNT_W-1:0] cmp_hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic [NEV-1:0]   ev_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  tmr_dir_e         dir_q, dir_d;
  logic             load;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!enable_i) begin
      dir_d = DIR_UP;
    end
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          cnt_d = (cnt_q == per_q) ? '0 : cnt_q + ONE;
        end
        MODE_UPDN: begin
          if (dir_q == DIR_UP) begin
            if (cnt_q == per_q) begin
              dir_d = DIR_DN;
              cnt_d = (per_q == '0) ? '0 : per_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d = DIR_UP;
              cnt_d = (per_q == '0) ? '0 : ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        MODE_DN: begin
          cnt_d = (cnt_q == '0) ? per_q : cnt_q - ONE;
        end
        default: begin
          cnt_d = cnt_q;
        end
      endcase
    end
    if (cnt_wr_i) begin
      cnt_d = cnt_wdata_i;
    end
  end

  always_comb begin
    load  = !enable_i || (tick_i && cnt_d == '0);
    per_d = load ? per_hold_i : per_q;
    cmp_d = load ? cmp_hold_i : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      per_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
    end
  end

  always_comb begin
    ev_o          = '0;
    ev_o[EV_PER]  = tick_i && (cnt_q == per_q);
    ev_o[EV_CMP]  = tick_i && (cnt_q == cmp_q);
    ev_o[EV_ZERO] = tick_i && (cnt_q == '0);
  end

  assign cnt_o     = cnt_q;
  assign cmp_act_o = cmp_q;

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && mode_i == MODE_UP && cnt_q == per_q && !cnt_wr_i) |=> (cnt_q == '0));

  assert_updn_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && mode_i == MODE_UPDN && dir_q == DIR_UP && cnt_q == per_q &&
     per_q != '0 && !cnt_wr_i) |=> (cnt_q == $past(per_q) - ONE));

  assert_dn_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && mode_i == MODE_DN && cnt_q == '0 && !cnt_wr_i) |=> (cnt_q == $past(per_q)));

  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));

  assert_period_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !(tick_i && cnt_d == '0)) |=> $stable(per_q));

endmodule

// File: rtl/pwm_tmr_events.sv
module pwm_tmr_events
  import pwm_tmr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic [NEV-1:0] ev_i,
  input  logic           clr_wr_i,
  input  logic [NEV-1:0] clr_bits_i,
  input  logic [NEV-1:0] mask_i,
  input  logic           adc_sel_i,
  output logic [NEV-1:0] flags_o,
  output logic           irq_o,
  output logic           adc_trig_o
);
  logic [NEV-1:0] flg_q, flg_d;
  logic           trg_q, trg_d;

  always_comb begin
    flg_d = flg_q;
    if (clr_wr_i) begin
      flg_d = flg_d & ~clr_bits_i;
    end
    flg_d = flg_d | ev_i;
    trg_d = adc_sel_i ? ev_i[EV_PER] : ev_i[EV_ZERO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      trg_q <= 1'b0;
    end else begin
      flg_q <= flg_d;
      trg_q <= trg_d;
    end
  end

  assign flags_o    = flg_q;
  assign irq_o      = |(flg_q & mask_i);
  assign adc_trig_o = trg_q;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[EV_ZERO] && !(clr_wr_i && clr_bits_i[EV_ZERO])) |=> flg_q[EV_ZERO]);

  assert_trig_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |-> $past(tick_i));

  assert_trig_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |-> (flg_q[EV_ZERO] || flg_q[EV_PER]));

endmodule

// File: rtl/pwm_gp_timer.sv
module pwm_gp_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PS_W  = 3,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out,
  output logic             adc_trig,
  output logic             irq
);
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned MODE_LO = 1;
  localparam int unsigned PS_LO   = 3;
  localparam int unsigned SEL_BIT = PS_LO + PS_W;
  localparam int unsigned CTRL_W  = SEL_BIT + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rsync_q[1];

  // register file
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  per_h_q, per_h_d;
  logic [CNT_W-1:0]  cmp_h_q, cmp_h_d;
  logic [NEV-1:0]    msk_q, msk_d;
  logic              wr_ctrl, wr_cnt, wr_cmp, wr_per, wr_flg, wr_msk;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == AW'(ADDR_CTRL));
    wr_cnt  = wr_en && (wr_addr == AW'(ADDR_CNT));
    wr_cmp  = wr_en && (wr_addr == AW'(ADDR_CMP));
    wr_per  = wr_en && (wr_addr == AW'(ADDR_PER));
    wr_flg  = wr_en && (wr_addr == AW'(ADDR_FLG));
    wr_msk  = wr_en && (wr_addr == AW'(ADDR_MSK));
    ctrl_d  = wr_ctrl ? wr_data[CTRL_W-1:0] : ctrl_q;
    per_h_d = wr_per  ? wr_data : per_h_q;
    cmp_h_d = wr_cmp  ? wr_data : cmp_h_q;
    msk_d   = wr_msk  ? wr_data[NEV-1:0] : msk_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q  <= '0;
      per_h_q <= '0;
      cmp_h_q <= '0;
      msk_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      per_h_q <= per_h_d;
      cmp_h_q <= cmp_h_d;
      msk_q   <= msk_d;
    end
  end

  logic            enable;
  tmr_mode_e       mode;
  logic [PS_W-1:0] ps;
  logic            adc_sel;

  assign enable  = ctrl_q[EN_BIT];
  assign mode    = tmr_mode_e'(ctrl_q[MODE_LO +: 2]);
  assign ps      = ctrl_q[PS_LO +: PS_W];
  assign adc_sel = ctrl_q[SEL_BIT];

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_act;
  logic [NEV-1:0]   ev;
  logic [NEV-1:0]   flags;

  pwm_tmr_prescaler #(.PS_W(PS_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .enable_i (enable),
    .clk_en_i (clk_en),
    .ps_i     (ps),
    .tick_o   (tick)
  );

  pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .enable_i    (enable),
    .tick_i      (tick),
    .mode_i      (mode),
    .cnt_wr_i    (wr_cnt),
    .cnt_wdata_i (wr_data),
    .per_hold_i  (per_h_q),
    .cmp_hold_i  (cmp_h_q),
    .cnt_o       (cnt),
    .cmp_act_o   (cmp_act),
    .ev_o        (ev)
  );

  pwm_tmr_events u_evt (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tick_i     (tick),
    .ev_i       (ev),
    .clr_wr_i   (wr_flg),
    .clr_bits_i (wr_data[NEV-1:0]),
    .mask_i     (msk_q),
    .adc_sel_i  (adc_sel),
    .flags_o    (flags),
    .irq_o      (irq),
    .adc_trig_o (adc_trig)
  );

  assign pwm_out = enable && (cnt < cmp_act);

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      AW'(ADDR_CTRL): rd_data = CNT_W'(ctrl_q);
      AW'(ADDR_CNT):  rd_data = cnt;
      AW'(ADDR_CMP):  rd_data = cmp_h_q;
      AW'(ADDR_PER):  rd_data = per_h_q;
      AW'(ADDR_FLG):  rd_data = CNT_W'(flags);
      AW'(ADDR_MSK):  rd_data = CNT_W'(msk_q);
      default:        rd_data = '0;
    endcase
  end

  assert_pwm_low_off_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !enable |-> !pwm_out);

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (msk_q == '0) |-> !irq);

endmodule

// File: tb/pwm_gp_timer_tb_top.sv
module pwm_gp_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        clk_en;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        pwm_out;
  logic        adc_trig;
  logic        irq;

  int n_checks;
  int n_fails;

  pwm_gp_timer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .adc_trig (adc_trig),
    .irq      (irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // {mode[1:0], ps[2:0], per[15:0], cmp[15:0], cycles[15:0]}
  localparam int NV = 6;
  localparam logic [52:0] VEC [NV] = '{
    {2'd0, 3'd0, 16'd5, 16'd3, 16'd20},
    {2'd1, 3'd0, 16'd4, 16'd2, 16'd24},
    {2'd2, 3'd0, 16'd3, 16'd2, 16'd16},
    {2'd0, 3'd2, 16'd3, 16'd1, 16'd40},
    {2'd1, 3'd1, 16'd2, 16'd3, 16'd30},
    {2'd0, 3'd0, 16'd0, 16'd0, 16'd6}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrl_word(input logic sel, input logic [2:0] ps,
                                            input logic [1:0] mode, input logic en);
    return {9'd0, sel, ps, mode, en};
  endfunction

  task automatic run_vector(input logic [52:0] v);
    logic [1:0]  mode;
    logic [2:0]  ps;
    logic [15:0] per, cmp, cyc, cnt, msk;
    logic [6:0]  div;
    logic        dn;
    string       tag;
    mode = v[52:51];
    ps   = v[50:48];
    per  = v[47:32];
    cmp  = v[31:16];
    cyc  = v[15:0];
    tag  = (ps != 0) ? "R6" : (mode == 2'd0) ? "R3" : (mode == 2'd1) ? "R4" : "R5";
    wr(3'd0, 16'd0);
    wr(3'd3, per);
    wr(3'd2, cmp);
    wr(3'd1, 16'd0);
    wr(3'd0, ctrl_word(1'b0, ps, mode, 1'b1));
    rd_addr = 3'd1;
    cnt = 0; div = 0; dn = 1'b0;
    msk = (16'd1 << ps) - 16'd1;
    for (int k = 0; k < int'(cyc); k++) begin
      @(negedge clk);
      if ((16'(div) & msk) == msk) begin
        case (mode)
          2'd0: cnt = (cnt == per) ? 16'd0 : cnt + 16'd1;
          2'd1: begin
            if (!dn) begin
              if (cnt == per) begin dn = 1'b1; cnt = (per == 0) ? 16'd0 : per - 16'd1; end
              else cnt = cnt + 16'd1;
            end else begin
              if (cnt == 0) begin dn = 1'b0; cnt = (per == 0) ? 16'd0 : 16'd1; end
              else cnt = cnt - 16'd1;
            end
          end
          2'd2: cnt = (cnt == 0) ? per : cnt - 16'd1;
          default: ;
        endcase
      end
      div = div + 7'd1;
      check(tag, rd_data, cnt);
      check("R7", {15'd0, pwm_out}, {15'd0, (cnt < cmp)});
    end
  endtask

  logic done;

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int first;
    int pulses;
    n_checks = 0;
    n_fails  = 0;
    rst_n    = 1'b0;
    clk_en   = 1'b1;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    rd_addr  = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state
    rd_addr = 3'd0; #1; check("R1", rd_data, 16'd0);
    rd_addr = 3'd1; #1; check("R1", rd_data, 16'd0);
    rd_addr = 3'd4; #1; check("R1", rd_data, 16'd0);
    rd_addr = 3'd5; #1; check("R1", rd_data, 16'd0);
    check("R1", {13'd0, pwm_out, adc_trig, irq}, 16'd0);

    // R2 count write and readback
    wr(3'd1, 16'h1234);
    rd_addr = 3'd1; #1; check("R2", rd_data, 16'h1234);
    wr(3'd2, 16'h00AB);
    rd_addr = 3'd2; #1; check("R2", rd_data, 16'h00AB);

    // vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      run_vector(VEC[i]);
    end

    // R8 holding copies load only at zero
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd9);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'd0);
    wr(3'd4, 16'd7);
    wr(3'd0, ctrl_word(1'b0, 3'd0, 2'd0, 1'b1));
    step(3);
    wr(3'd3, 16'd2);
    rd_addr = 3'd3; #1; check("R2", rd_data, 16'd2);
    rd_addr = 3'd1;
    step(5); check("R8", rd_data, 16'd9);
    step(1); check("R8", rd_data, 16'd0);
    step(3); check("R8", rd_data, 16'd0);

    // R9 flags and W1C, R10 irq
    wr(3'd0, 16'd0);
    rd_addr = 3'd4; #1; check("R9", rd_data, 16'd7);
    check("R10", {15'd0, irq}, 16'd0);
    wr(3'd4, 16'd1);
    #1; check("R9", rd_data, 16'd6);
    wr(3'd5, 16'd4);
    rd_addr = 3'd5; #1; check("R2", rd_data, 16'd4);
    check("R10", {15'd0, irq}, 16'd1);
    wr(3'd4, 16'd4);
    rd_addr = 3'd4; #1; check("R9", rd_data, 16'd2);
    check("R10", {15'd0, irq}, 16'd0);

    // R6 clk_en gating and hold mode
    wr(3'd3, 16'd9);
    wr(3'd1, 16'd0);
    clk_en = 1'b0;
    wr(3'd0, ctrl_word(1'b0, 3'd0, 2'd0, 1'b1));
    rd_addr = 3'd1;
    step(5); check("R6", rd_data, 16'd0);
    clk_en = 1'b1;
    step(2); check("R6", rd_data, 16'd2);
    wr(3'd0, ctrl_word(1'b0, 3'd0, 2'd3, 1'b1));
    check("R6", rd_data, 16'd3);
    step(3); check("R6", rd_data, 16'd3);

    // R11 trigger on zero event
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd3);
    wr(3'd1, 16'd0);
    wr(3'd0, ctrl_word(1'b0, 3'd0, 2'd0, 1'b1));
    first = 0; pulses = 0;
    for (int k = 1; k <= 8; k++) begin
      step(1);
      if (adc_trig) begin pulses++; if (first == 0) first = k; end
    end
    check("R11", 16'(first), 16'd1);
    check("R11", 16'(pulses), 16'd2);

    // R11 trigger on period event
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd0);
    wr(3'd0, ctrl_word(1'b1, 3'd0, 2'd0, 1'b1));
    first = 0; pulses = 0;
    for (int k = 1; k <= 8; k++) begin
      step(1);
      if (adc_trig) begin pulses++; if (first == 0) first = k; end
    end
    check("R11", 16'(first), 16'd4);
    check("R11", 16'(pulses), 16'd2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule